// File: doc/BRIEF.md
# Ethernet PHY Link Poll and Mode Resolution Engine

This block watches the link of two Ethernet PHYs and keeps the MAC-side port configuration in step with them. At a fixed interval, given as a parameter in clock cycles, it walks the ports in ascending order. For each port it reads the PHY's standard status register through a simple MDIO command interface (request, PHY address, register address, busy, read data). When the link bit differs from the value remembered for that port, it reads more registers. From these it works out speed, duplex and pause, and then drives per-port speed, duplex, flow-control-enable and link-force outputs.

On link loss the link-force output is dropped and the status register is read once more, because the PHY latches its link bit low. When the link is up and auto-negotiation finished, the engine takes the best mode that both link partners can use, covering both the gigabit and the 10/100 ability registers. Otherwise it uses the forced settings in the control register. Sweeps start only while the global switch-enable input is high. The MDIO serial shifter sits outside this block.

Top module: `phy_link_poll`

## Requirements
- R1: A synchronous active-high reset clears every MAC-side output and the MDIO request, and marks each port's remembered link state as unknown, so the first sweep after reset treats any PHY it finds as a link change.
- R2: A timer fires every POLL_CYCLES clock cycles. A sweep starts on a timer pulse only while sw_enable is high. A sweep visits port 0 before port 1. While sw_enable is low, no MDIO request is issued.
- R3: mdio_req is a one-cycle pulse. It is raised only while mdio_busy is low. The responder raises mdio_busy on the clock edge that samples the request and holds it high until the data is ready. The engine takes mdio_rdata in the first cycle in which mdio_busy is low again.
- R4: If a status register (address 1) read returns 0x0000 or 0xFFFF, the port has no PHY. The engine makes no further access for that port in the sweep and changes no output or remembered state.
- R5: If link bit 2 of the status register matches the remembered state, the status read is the only access for that port and no output changes.
- R6: When the link bit reads 0 and this is a change, the port's link-force output clears and the status register is read a second time. If the second read still shows link down, the remembered state becomes down and all other outputs keep their values. If it shows link up, resolution proceeds using the second value.
- R7: On link up the engine reads control (0) and then advertisement (4). Only when control bit 12 and status bit 5 are both set does it then read partner ability (5), gigabit control (9) and gigabit status (10), in that order.
- R8: In auto-negotiated mode the engine takes the best common mode, from best to worst: 1G full (reg9 bit 9 and reg10 bit 11), 1G half (reg9 bit 8 and reg10 bit 10), 100M full (bit 8 of reg4 and reg5), 100M half (bit 7), 10M full (bit 6). If none of these is shared, it uses 10M half. The speed code is 0 for 10M, 1 for 100M and 2 for 1G, and is never 3. Duplex is 1 for full.
- R9: In auto-negotiated mode, pause is bit 10 of reg4 AND reg5.
- R10: Without auto-negotiation, pause is reg4 bit 10. Speed is 2 if reg0 bit 6 is set, else reg0 bit 13. Duplex is reg0 bit 8.
- R11: After resolution, the port's speed, duplex and pause take the resolved values, its link-force output goes high, and the remembered state becomes up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sw_enable | input | 1 | Global switch enable; gates the start of sweeps |
| phy_addr | input | NPORTS*5 | PHY address per port, port 0 in the low bits |
| mdio_req | output | 1 | One-cycle MDIO read request |
| mdio_phy | output | 5 | PHY address of the request |
| mdio_reg | output | 5 | Register address of the request |
| mdio_busy | input | 1 | MDIO transaction in progress |
| mdio_rdata | input | 16 | Read data, valid when busy falls |
| mac_speed | output | NPORTS*2 | Speed code per port (0 10M, 1 100M, 2 1G) |
| mac_duplex | output | NPORTS | Full duplex per port |
| mac_pause | output | NPORTS | Flow-control enable per port |
| mac_link | output | NPORTS | Link-force per port |

## Verification
In one cycle, the MDIO completion (busy falling with data) both ends the current access and lets the sequencer pick its next register. The next request must still wait for the following cycle, when the bus is idle. The bench's responder drops busy and presents data on the same edge and answers every request after a fixed latency, so every access in a sweep runs into this overlap. It is judged by the scoreboard: each request must match the next expected (PHY, register) pair, no request may appear while busy is high or two cycles in a row, and the outputs at the end of the sweep must show that the right word was captured each time. The latched-low case forces a link drop and a relink into the same sweep, and the checks confirm that the final state comes from the second status value.

// File: rtl/phy_poll_pkg.sv
package phy_poll_pkg;

  typedef enum logic [1:0] {
    LS_UNKNOWN = 2'd0,
    LS_DOWN    = 2'd1,
    LS_UP      = 2'd2
  } link_hist_t;

  typedef struct packed {
    logic [1:0] speed;
    logic       duplex;
    logic       pause;
  } port_mode_t;

  localparam logic [1:0] SPD_10M   = 2'd0;
  localparam logic [1:0] SPD_100M  = 2'd1;
  localparam logic [1:0] SPD_1000M = 2'd2;

  localparam logic [4:0] MREG_CTRL  = 5'd0;
  localparam logic [4:0] MREG_STAT  = 5'd1;
  localparam logic [4:0] MREG_ADV   = 5'd4;
  localparam logic [4:0] MREG_LPA   = 5'd5;
  localparam logic [4:0] MREG_GCTRL = 5'd9;
  localparam logic [4:0] MREG_GSTAT = 5'd10;

  // All-ones or all-zeros status means nothing answered on that address
  function automatic logic phy_absent(input logic [15:0] stat);
    return (stat == 16'hFFFF) || (stat == 16'h0000);
  endfunction

  // Auto-negotiation counts only when enabled in control and done in status
  function automatic logic an_resolved(input logic [15:0] ctrl,
                                       input logic [15:0] stat);
    return ctrl[12] & stat[5];
  endfunction

  // Shared ability vector: [5] 1G-FD, [4] 1G-HD, [3] 100-FD, [2] 100-HD,
  // [1] 10-FD, [0] 10-HD
  function automatic logic [5:0] common_ability(input logic [15:0] adv,
                                                input logic [15:0] lpa,
                                                input logic [15:0] gctl,
                                                input logic [15:0] gsts);
    logic [15:0] giga;
    logic [15:0] base;
    giga = {gctl[13:0], 2'b00} & gsts & 16'h0C00;
    base = adv & lpa & 16'h01E0;
    return {giga[11:10], base[8:5]};
  endfunction

  function automatic port_mode_t resolve_auto(input logic [15:0] adv,
                                              input logic [15:0] lpa,
                                              input logic [15:0] gctl,
                                              input logic [15:0] gsts);
    port_mode_t m;
    logic [5:0] ab;
    ab       = common_ability(adv, lpa, gctl, gsts);
    m.pause  = adv[10] & lpa[10];
    if (ab[5])      begin m.speed = SPD_1000M; m.duplex = 1'b1; end
    else if (ab[4]) begin m.speed = SPD_1000M; m.duplex = 1'b0; end
    else if (ab[3]) begin m.speed = SPD_100M;  m.duplex = 1'b1; end
    else if (ab[2]) begin m.speed = SPD_100M;  m.duplex = 1'b0; end
    else if (ab[1]) begin m.speed = SPD_10M;   m.duplex = 1'b1; end
    else            begin m.speed = SPD_10M;   m.duplex = 1'b0; end
    return m;
  endfunction

  function automatic port_mode_t resolve_forced(input logic [15:0] ctrl,
                                                input logic [15:0] adv);
    port_mode_t m;
    m.pause  = adv[10];
    m.speed  = ctrl[6] ? SPD_1000M : {1'b0, ctrl[13]};
    m.duplex = ctrl[8];
    return m;
  endfunction

endpackage

// File: rtl/poll_timer.sv
module poll_timer #(
  parameter int unsigned PERIOD = 100_000_000
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      tick <= wrap;
      cnt  <= wrap ? '0 : cnt + 1'b1;
    end
  end

endmodule

// File: rtl/mdio_access.sv
module mdio_access #(
  parameter int AW = 5,
  parameter int RW = 5,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] phy_in,
  input  logic [RW-1:0] reg_in,
  output logic          mdio_req,
  output logic [AW-1:0] mdio_phy,
  output logic [RW-1:0] mdio_reg,
  input  logic          mdio_busy,
  input  logic [DW-1:0] mdio_rdata,
  output logic          done,
  output logic [DW-1:0] rdata
);
  typedef enum logic [1:0] {A_IDLE, A_REQ, A_WAIT} acc_st_t;

  acc_st_t st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= A_IDLE;
      mdio_req <= 1'b0;
      mdio_phy <= '0;
      mdio_reg <= '0;
    end else begin
      case (st)
        A_IDLE: if (start && !mdio_busy) begin
          mdio_req <= 1'b1;
          mdio_phy <= phy_in;
          mdio_reg <= reg_in;
          st       <= A_REQ;
        end
        A_REQ: begin
          mdio_req <= 1'b0;
          st       <= A_WAIT;
        end
        A_WAIT: if (!mdio_busy) st <= A_IDLE;
        default: st <= A_IDLE;
      endcase
    end
  end

  assign done  = (st == A_WAIT) && !mdio_busy;
  assign rdata = mdio_rdata;

  assert_req_on_idle_bus_R3: assert property (@(posedge clk) disable iff (rst)
    mdio_req |-> !mdio_busy)
    else $error("request raised while bus busy");

  assert_req_single_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    mdio_req |=> !mdio_req)
    else $error("request held longer than one cycle");

endmodule

// File: rtl/link_fsm.sv
module link_fsm
  import phy_poll_pkg::*;
#(
  parameter int NPORTS = 2,
  parameter int AW     = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick,
  input  logic                 sw_enable,
  input  logic [NPORTS*AW-1:0] phy_addr,
  output logic                 acc_start,
  output logic [AW-1:0]        acc_phy,
  output logic [4:0]           acc_reg,
  input  logic                 acc_done,
  input  logic [15:0]          acc_data,
  output logic [NPORTS-1:0]    link_clr,
  output logic [NPORTS-1:0]    apply_en,
  output port_mode_t           apply_mode
);
  localparam int PW = (NPORTS > 1) ? $clog2(NPORTS) : 1;
  localparam logic [PW-1:0] LAST_PORT = PW'(NPORTS - 1);

  typedef enum logic [3:0] {
    S_IDLE, S_RD_STAT, S_RD_STAT2, S_RD_CTRL, S_RD_ADV,
    S_RD_LPA, S_RD_GCTRL, S_RD_GSTAT, S_APPLY, S_NEXT
  } sweep_st_t;

  sweep_st_t  st;
  logic [PW-1:0] port;
  link_hist_t hist [NPORTS];
  logic [15:0] r_ctrl, r_stat, r_adv, r_lpa, r_gctl, r_gsts;
  logic        an_q;

  // Named events for the checks
  logic stat_link;
  logic changed;
  logic absent_evt;
  logic link_drop_evt;

  assign stat_link = acc_data[2];

  always_comb begin
    changed       = (hist[port] == LS_UNKNOWN) ||
                    ((hist[port] == LS_UP) != stat_link);
    absent_evt    = (st == S_RD_STAT) && acc_done && phy_absent(acc_data);
    link_drop_evt = (st == S_RD_STAT) && acc_done && !phy_absent(acc_data) &&
                    changed && !stat_link;
  end

  always_comb begin
    case (st)
      S_RD_STAT, S_RD_STAT2: acc_reg = MREG_STAT;
      S_RD_CTRL:             acc_reg = MREG_CTRL;
      S_RD_ADV:              acc_reg = MREG_ADV;
      S_RD_LPA:              acc_reg = MREG_LPA;
      S_RD_GCTRL:            acc_reg = MREG_GCTRL;
      S_RD_GSTAT:            acc_reg = MREG_GSTAT;
      default:               acc_reg = MREG_STAT;
    endcase
  end

  assign acc_start  = (st == S_RD_STAT) || (st == S_RD_STAT2) || (st == S_RD_CTRL) ||
                      (st == S_RD_ADV)  || (st == S_RD_LPA)   || (st == S_RD_GCTRL) ||
                      (st == S_RD_GSTAT);
  assign acc_phy    = phy_addr[port*AW +: AW];
  assign link_clr   = link_drop_evt ? (NPORTS'(1) << port) : '0;
  assign apply_en   = (st == S_APPLY) ? (NPORTS'(1) << port) : '0;
  assign apply_mode = an_q ? resolve_auto(r_adv, r_lpa, r_gctl, r_gsts)
                           : resolve_forced(r_ctrl, r_adv);

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= S_IDLE;
      port   <= '0;
      an_q   <= 1'b0;
      r_ctrl <= '0;
      r_stat <= '0;
      r_adv  <= '0;
      r_lpa  <= '0;
      r_gctl <= '0;
      r_gsts <= '0;
      for (int i = 0; i < NPORTS; i++) hist[i] <= LS_UNKNOWN;
    end else begin
      case (st)
        S_IDLE: if (tick && sw_enable) begin
          port <= '0;
          st   <= S_RD_STAT;
        end
        S_RD_STAT: if (acc_done) begin
          if (phy_absent(acc_data)) st <= S_NEXT;
          else begin
            r_stat <= acc_data;
            if (!changed)        st <= S_NEXT;
            else if (!stat_link) st <= S_RD_STAT2;
            else                 st <= S_RD_CTRL;
          end
        end
        S_RD_STAT2: if (acc_done) begin
          r_stat <= acc_data;
          if (acc_data[2]) st <= S_RD_CTRL;
          else begin
            hist[port] <= LS_DOWN;
            st         <= S_NEXT;
          end
        end
        S_RD_CTRL: if (acc_done) begin
          r_ctrl <= acc_data;
          st     <= S_RD_ADV;
        end
        S_RD_ADV: if (acc_done) begin
          r_adv <= acc_data;
          an_q  <= an_resolved(r_ctrl, r_stat);
          st    <= an_resolved(r_ctrl, r_stat) ? S_RD_LPA : S_APPLY;
        end
        S_RD_LPA: if (acc_done) begin
          r_lpa <= acc_data;
          st    <= S_RD_GCTRL;
        end
        S_RD_GCTRL: if (acc_done) begin
          r_gctl <= acc_data;
          st     <= S_RD_GSTAT;
        end
        S_RD_GSTAT: if (acc_done) begin
          r_gsts <= acc_data;
          st     <= S_APPLY;
        end
        S_APPLY: begin
          hist[port] <= LS_UP;
          st         <= S_NEXT;
        end
        S_NEXT: begin
          if (port == LAST_PORT) st <= S_IDLE;
          else begin
            port <= port + 1'b1;
            st   <= S_RD_STAT;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_sweep_gated_R2: assert property (@(posedge clk) disable iff (rst)
    (st == S_IDLE && !sw_enable) |=> (st == S_IDLE))
    else $error("sweep started while switch disabled");

  assert_reread_after_drop_R6: assert property (@(posedge clk) disable iff (rst)
    link_drop_evt |=> (st == S_RD_STAT2 && acc_start && acc_reg == MREG_STAT))
    else $error("status not re-read after link drop");

  assert_absent_skips_R4: assert property (@(posedge clk) disable iff (rst)
    absent_evt |=> (st == S_NEXT && $stable(port)))
    else $error("absent PHY not skipped");

endmodule

// File: rtl/port_cfg_bank.sv
module port_cfg_bank
  import phy_poll_pkg::*;
#(
  parameter int NPORTS = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NPORTS-1:0]     link_clr,
  input  logic [NPORTS-1:0]     apply_en,
  input  port_mode_t            apply_mode,
  output logic [2*NPORTS-1:0]   mac_speed,
  output logic [NPORTS-1:0]     mac_duplex,
  output logic [NPORTS-1:0]     mac_pause,
  output logic [NPORTS-1:0]     mac_link
);
  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    port_mode_t mode_q;
    logic       link_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        mode_q <= '0;
        link_q <= 1'b0;
      end else if (apply_en[p]) begin
        mode_q <= apply_mode;
        link_q <= 1'b1;
      end else if (link_clr[p]) begin
        link_q <= 1'b0;
      end
    end

    assign mac_speed[2*p +: 2] = mode_q.speed;
    assign mac_duplex[p]       = mode_q.duplex;
    assign mac_pause[p]        = mode_q.pause;
    assign mac_link[p]         = link_q;

    assert_drop_clears_link_R6: assert property (@(posedge clk) disable iff (rst)
      link_clr[p] |=> (!mac_link[p] && $stable(mac_speed[2*p +: 2])))
      else $error("link drop did not clear link-force only");

    assert_apply_sets_link_R11: assert property (@(posedge clk) disable iff (rst)
      apply_en[p] |=> (mac_link[p] &&
                       mac_speed[2*p +: 2] == $past(apply_mode.speed) &&
                       mac_duplex[p] == $past(apply_mode.duplex) &&
                       mac_pause[p]  == $past(apply_mode.pause)))
      else $error("resolved mode not applied");

    assert_speed_code_legal_R8: assert property (@(posedge clk) disable iff (rst)
      mac_speed[2*p +: 2] != 2'd3)
      else $error("illegal speed code");
  end

endmodule

// File: rtl/phy_link_poll.sv
module phy_link_poll
  import phy_poll_pkg::*;
#(
  parameter int          NPORTS      = 2,
  parameter int          PHY_AW      = 5,
  parameter int unsigned POLL_CYCLES = 100_000_000
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     sw_enable,
  input  logic [NPORTS*PHY_AW-1:0] phy_addr,
  output logic                     mdio_req,
  output logic [PHY_AW-1:0]        mdio_phy,
  output logic [4:0]               mdio_reg,
  input  logic                     mdio_busy,
  input  logic [15:0]              mdio_rdata,
  output logic [2*NPORTS-1:0]      mac_speed,
  output logic [NPORTS-1:0]        mac_duplex,
  output logic [NPORTS-1:0]        mac_pause,
  output logic [NPORTS-1:0]        mac_link
);
  logic              poll_tick;
  logic              acc_start;
  logic [PHY_AW-1:0] acc_phy;
  logic [4:0]        acc_reg;
  logic              acc_done;
  logic [15:0]       acc_data;
  logic [NPORTS-1:0] link_clr;
  logic [NPORTS-1:0] apply_en;
  port_mode_t        apply_mode;

  poll_timer #(.PERIOD(POLL_CYCLES)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .tick (poll_tick)
  );

  link_fsm #(.NPORTS(NPORTS), .AW(PHY_AW)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .tick       (poll_tick),
    .sw_enable  (sw_enable),
    .phy_addr   (phy_addr),
    .acc_start  (acc_start),
    .acc_phy    (acc_phy),
    .acc_reg    (acc_reg),
    .acc_done   (acc_done),
    .acc_data   (acc_data),
    .link_clr   (link_clr),
    .apply_en   (apply_en),
    .apply_mode (apply_mode)
  );

  mdio_access #(.AW(PHY_AW), .RW(5), .DW(16)) u_acc (
    .clk        (clk),
    .rst        (rst),
    .start      (acc_start),
    .phy_in     (acc_phy),
    .reg_in     (acc_reg),
    .mdio_req   (mdio_req),
    .mdio_phy   (mdio_phy),
    .mdio_reg   (mdio_reg),
    .mdio_busy  (mdio_busy),
    .mdio_rdata (mdio_rdata),
    .done       (acc_done),
    .rdata      (acc_data)
  );

  port_cfg_bank #(.NPORTS(NPORTS)) u_bank (
    .clk        (clk),
    .rst        (rst),
    .link_clr   (link_clr),
    .apply_en   (apply_en),
    .apply_mode (apply_mode),
    .mac_speed  (mac_speed),
    .mac_duplex (mac_duplex),
    .mac_pause  (mac_pause),
    .mac_link   (mac_link)
  );

endmodule

// File: tb/sim_phy_link_poll.sv
`timescale 1ns/1ps
module sim_phy_link_poll;
  localparam int POLL = 256;
  localparam int LAT  = 3;
  localparam logic [4:0] A0 = 5'd3;
  localparam logic [4:0] A1 = 5'd17;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst, sw_en;
  logic        mdio_req, mdio_busy;
  logic [4:0]  mdio_phy, mdio_reg;
  logic [15:0] mdio_rdata;
  logic [3:0]  mac_speed;
  logic [1:0]  mac_duplex, mac_pause, mac_link;

  phy_link_poll #(.NPORTS(2), .PHY_AW(5), .POLL_CYCLES(POLL)) u0 (
    .clk(clk), .rst(rst), .sw_enable(sw_en), .phy_addr({A1, A0}),
    .mdio_req(mdio_req), .mdio_phy(mdio_phy), .mdio_reg(mdio_reg),
    .mdio_busy(mdio_busy), .mdio_rdata(mdio_rdata),
    .mac_speed(mac_speed), .mac_duplex(mac_duplex),
    .mac_pause(mac_pause), .mac_link(mac_link)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit finished = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // PHY model: register file per port plus a one-shot latched status value
  logic [15:0] preg [2][32];
  bit          latch_en [2];
  int          latch_at [2];
  logic [15:0] latch_val [2];
  int          stat_reads [2];
  int          busy_cnt;
  logic [4:0]  q_phy, q_reg;

  function automatic int pidx(input logic [4:0] a);
    if (a == A0) return 0;
    if (a == A1) return 1;
    return -1;
  endfunction

  function automatic logic [15:0] model_read(input logic [4:0] a, input logic [4:0] r);
    int p;
    p = pidx(a);
    if (p < 0) return 16'hFFFF;
    if (r == 5'd1 && latch_en[p] && stat_reads[p] == latch_at[p]) return latch_val[p];
    return preg[p][r];
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst) begin
      mdio_busy  <= 1'b0;
      mdio_rdata <= '0;
      busy_cnt   <= 0;
      stat_reads[0] <= 0;
      stat_reads[1] <= 0;
    end else if (mdio_req) begin
      mdio_busy <= 1'b1;
      busy_cnt  <= LAT;
      q_phy     <= mdio_phy;
      q_reg     <= mdio_reg;
    end else if (mdio_busy) begin
      if (busy_cnt == 0) begin
        mdio_busy  <= 1'b0;
        mdio_rdata <= model_read(q_phy, q_reg);
        if (q_reg == 5'd1 && pidx(q_phy) >= 0)
          stat_reads[pidx(q_phy)] <= stat_reads[pidx(q_phy)] + 1;
      end else begin
        busy_cnt <= busy_cnt - 1;
      end
    end
  end

  // Scoreboard of expected (phy, register) accesses
  logic [9:0] exp_q [$];
  int         stamps [$];
  logic       req_d = 1'b0;

  always @(negedge clk) begin
    if (!rst && mdio_req) begin
      stamps.push_back(cyc);
      chk("R3 request while busy", {31'd0, mdio_busy}, 32'd0);
      chk("R3 request longer than a pulse", {31'd0, req_d}, 32'd0);
      if (exp_q.size() == 0) begin
        chk("R2 unexpected access", {22'd0, mdio_phy, mdio_reg}, 32'h3FF);
      end else begin
        logic [9:0] e;
        e = exp_q.pop_front();
        chk("R7 access order", {22'd0, mdio_phy, mdio_reg}, {22'd0, e});
      end
    end
    req_d <= mdio_req;
  end

  task automatic expect_rd(input int p, input int r);
    exp_q.push_back({(p == 0) ? A0 : A1, 5'(r)});
  endtask

  task automatic set_port(input int p, input logic [15:0] c0, input logic [15:0] s1,
                          input logic [15:0] a4, input logic [15:0] l5,
                          input logic [15:0] g9, input logic [15:0] g10);
    preg[p][0] = c0; preg[p][1] = s1; preg[p][4] = a4;
    preg[p][5] = l5; preg[p][9] = g9; preg[p][10] = g10;
  endtask

  task automatic sweep(input string tag);
    int t;
    @(negedge clk) sw_en = 1'b1;
    t = 0;
    while (exp_q.size() != 0 && t < 5000) begin
      @(negedge clk);
      t++;
    end
    repeat (12) @(negedge clk);
    sw_en = 1'b0;
    chk({tag, " sweep completed"}, {31'd0, (t < 5000)}, 32'd1);
    exp_q.delete();
  endtask

  task automatic chk_port(input string tag, input int p, input logic [1:0] spd,
                          input logic dup, input logic pau, input logic lnk);
    chk({tag, " speed"},  {30'd0, mac_speed[2*p +: 2]}, {30'd0, spd});
    chk({tag, " duplex"}, {31'd0, mac_duplex[p]}, {31'd0, dup});
    chk({tag, " pause"},  {31'd0, mac_pause[p]}, {31'd0, pau});
    chk({tag, " link"},   {31'd0, mac_link[p]}, {31'd0, lnk});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int b;
    rst = 1'b1;
    sw_en = 1'b0;
    for (int p = 0; p < 2; p++) begin
      for (int r = 0; r < 32; r++) preg[p][r] = 16'h0000;
      latch_en[p] = 0; latch_at[p] = 0; latch_val[p] = 16'h0;
    end
    preg[1][1] = 16'hFFFF;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: everything cleared after reset
    chk_port("R1 reset p0", 0, 2'd0, 1'b0, 1'b0, 1'b0);
    chk_port("R1 reset p1", 1, 2'd0, 1'b0, 1'b0, 1'b0);
    chk("R1 reset request", {31'd0, mdio_req}, 32'd0);

    // R7 R8 R9 R11: port 0 negotiated 1G full with pause; R4 port 1 absent (0xFFFF)
    set_port(0, 16'h1000, 16'h0024, 16'h05E1, 16'h45E1, 16'h0300, 16'h0C00);
    expect_rd(0, 1); expect_rd(0, 0); expect_rd(0, 4);
    expect_rd(0, 5); expect_rd(0, 9); expect_rd(0, 10);
    expect_rd(1, 1);
    sweep("R7");
    chk_port("R8 1G full p0", 0, 2'd2, 1'b1, 1'b1, 1'b1);
    chk_port("R4 absent p1", 1, 2'd0, 1'b0, 1'b0, 1'b0);

    // R5 unchanged link, R4 status 0x0000, R2 two sweeps one period apart
    preg[1][1] = 16'h0000;
    for (int k = 0; k < 2; k++) begin
      expect_rd(0, 1);
      expect_rd(1, 1);
    end
    b = stamps.size();
    sweep("R5");
    if (stamps.size() >= b + 3)
      chk("R2 poll period", 32'(stamps[b+2] - stamps[b]), POLL);
    else
      chk("R2 poll period accesses", 32'(stamps.size() - b), 32'd4);
    chk_port("R5 unchanged p0", 0, 2'd2, 1'b1, 1'b1, 1'b1);
    chk_port("R4 zero status p1", 1, 2'd0, 1'b0, 1'b0, 1'b0);

    // R10: port 1 forced 100M full, pause from advertisement
    set_port(1, 16'h2100, 16'h0004, 16'h0400, 16'h0000, 16'h0000, 16'h0000);
    expect_rd(0, 1);
    expect_rd(1, 1); expect_rd(1, 0); expect_rd(1, 4);
    sweep("R10");
    chk_port("R10 forced 100M p1", 1, 2'd1, 1'b1, 1'b1, 1'b1);

    // R6: port 0 link lost, re-read still down, mode kept
    preg[0][1] = 16'h0020;
    expect_rd(0, 1); expect_rd(0, 1);
    expect_rd(1, 1);
    sweep("R6");
    chk_port("R6 link lost p0", 0, 2'd2, 1'b1, 1'b1, 1'b0);
    chk_port("R5 steady p1", 1, 2'd1, 1'b1, 1'b1, 1'b1);

    // R6: port 1 latched-low, re-read up, negotiated 100M half, no pause (R9)
    set_port(1, 16'h1000, 16'h0024, 16'h01E1, 16'h00A1, 16'h0200, 16'h0400);
    latch_en[1] = 1; latch_at[1] = stat_reads[1]; latch_val[1] = 16'h0001;
    expect_rd(0, 1);
    expect_rd(1, 1); expect_rd(1, 1); expect_rd(1, 0); expect_rd(1, 4);
    expect_rd(1, 5); expect_rd(1, 9); expect_rd(1, 10);
    sweep("R6");
    latch_en[1] = 0;
    chk_port("R6 relinked 100M half p1", 1, 2'd1, 1'b0, 1'b0, 1'b1);
    chk_port("R5 still down p0", 0, 2'd2, 1'b1, 1'b1, 1'b0);

    // R10: complete bit set but negotiation disabled -> forced 1G half
    set_port(0, 16'h0040, 16'h0024, 16'h0000, 16'hFFFF, 16'hFFFF, 16'hFFFF);
    expect_rd(0, 1); expect_rd(0, 0); expect_rd(0, 4);
    expect_rd(1, 1);
    sweep("R10");
    chk_port("R10 forced 1G p0", 0, 2'd2, 1'b0, 1'b0, 1'b1);

    // R6 then R8: drop port 0, then negotiate 10M full only
    preg[0][1] = 16'h0020;
    expect_rd(0, 1); expect_rd(0, 1); expect_rd(1, 1);
    sweep("R6");
    chk("R6 link lost p0 again", {31'd0, mac_link[0]}, 32'd0);
    set_port(0, 16'h1000, 16'h0024, 16'h0041, 16'h0061, 16'h0000, 16'h0000);
    expect_rd(0, 1); expect_rd(0, 0); expect_rd(0, 4);
    expect_rd(0, 5); expect_rd(0, 9); expect_rd(0, 10);
    expect_rd(1, 1);
    sweep("R8");
    chk_port("R8 10M full p0", 0, 2'd0, 1'b1, 1'b0, 1'b1);

    // R2: switch disabled, no access over several periods
    b = stamps.size();
    repeat (3 * POLL) @(negedge clk);
    chk("R2 disabled no access", 32'(stamps.size() - b), 32'd0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule